// File: doc/BRIEF.md
# Serial ADC Control-Byte Interface

This block is the digital front end of a 12-bit, 8-channel serial converter as seen from the device side. A host drives an active-low chip select, a serial clock and a data-in line. The block watches the data line for a start bit. It collects the control byte that the start bit opens and decodes its channel, polarity, input-configuration and clock-mode fields. It then runs a conversion and returns the result on a serial data-out line, most significant bit first, followed by zeros. All serial pins are sampled by the block's own system clock, so the serial clock must stay in each level for at least two system clocks.

The analog conversion is modelled by a down-counter of `CONV_CYCLES` system clocks. When the count runs out, the result is taken from the `conv_data` port. A strobe output pulses when the result is ready. Once enough of a result has been shifted out, a new control byte can be clocked in while the remaining result bits are still leaving. This lets the host run one conversion every 15 serial clocks. The tri-state control of data-out is brought out as an enable pin.

Top module: `adc_serial_ctl`

## Requirements
- R1: While reset is held, `dout` is 0, `sstrb` is 0, all decoded field outputs are 0, and `dout_en` is 0 while `cs_n` is high.
- R2: With `cs_n` low and no conversion or readout in progress, a 0 on `din` at an SCLK rising edge is ignored. The first 1 seen at a rising edge is taken as the start bit and is the first bit of the control byte.
- R3: The control byte arrives in this order: start, channel bit 2, channel bit 1, channel bit 0, unipolar (1 = unipolar), single-ended (1 = single-ended), mode bit 1, mode bit 0. `chan_sel` = {channel bits 2..0} and `clk_mode` = {mode bit 1, mode bit 0}. All fields are updated on the rising edge that delivers the eighth bit, and they do not change while a conversion runs.
- R4: A conversion starts on the first SCLK falling edge after the eighth bit. `sstrb` goes high exactly `CONV_CYCLES` system clocks after the system-clock edge that detects that falling edge and stays high for one system clock. `conv_data` is sampled at that point.
- R5: After a conversion, each SCLK falling edge with `cs_n` low moves the next result bit onto `dout`: B11 on the 1st fall, B0 on the 12th fall, and 0 on every later fall.
- R6: During a readout, a 1 on `din` at a rising edge before the 7th falling edge (the one that shows B5) does not open a control byte.
- R7: After the 7th falling edge of a readout, a 1 on `din` at a rising edge opens a new control byte while the readout continues. The falling edge after that byte's eighth bit starts the next conversion and clears `dout`, so a full cycle takes 15 serial clocks.
- R8: While `cs_n` is high, `dout_en` is 0, SCLK and `din` are ignored, `dout` holds its value and a running conversion continues. A readout with no bits shifted yet survives the next falling edge of `cs_n`.
- R9: A falling edge of `cs_n` discards a partly received control byte and any readout that has already shifted at least one bit. `dout` returns to 0 and the start-bit search resumes at once.
- R10: With `clk_mode` = 11 (external clock), `sstrb` stays 0 when a conversion ends. Every other mode gives the R4 pulse. The readout is the same in all modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control input |
| conv_data | input | RES_BITS | Conversion result, sampled when the timer expires |
| dout | output | 1 | Serial result output |
| dout_en | output | 1 | Output enable for `dout` (high while selected) |
| sstrb | output | 1 | End-of-conversion strobe |
| chan_sel | output | 3 | Decoded channel select |
| unipolar | output | 1 | Decoded unipolar flag |
| single_ended | output | 1 | Decoded single-ended flag |
| clk_mode | output | 2 | Decoded clock/power mode field |

## Verification
The bench builds the block with `CONV_CYCLES` = 20 instead of the default 2000, `RES_BITS` = 12 and `EARLY_BIT` = 5. It drives SCLK with a half period of two system clocks. The short conversion time lets one run cover back-to-back frames, the 15-clock overlapped restart, early start bits that must be rejected, a select raised during a conversion and an abort in mid-readout. With a 12-bit result and B5 as the release point, the 7th and 8th falling edges are where early start bits stop being rejected and where a new control byte may begin, so both edges are exercised.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  localparam int CTRL_BITS = 8;

  localparam logic [1:0] MODE_EXT = 2'b11;
  localparam logic [1:0] MODE_INT = 2'b10;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_READ = 2'd2
  } phase_t;

  typedef struct packed {
    logic [2:0] chan;
    logic       unipolar;
    logic       single_ended;
    logic [1:0] clk_mode;
  } ctrl_fields_t;

  // Bits after the start bit, oldest first in the top position.
  function automatic ctrl_fields_t decode_ctrl(input logic [CTRL_BITS-2:0] b);
    ctrl_fields_t f;
    f.chan         = b[6:4];
    f.unipolar     = b[3];
    f.single_ended = b[2];
    f.clk_mode     = b[1:0];
    return f;
  endfunction

endpackage

// File: rtl/adc_pin_sampler.sv
module adc_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall
);

  logic sclk_q;
  logic cs_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_n_q <= cs_n;
    end
  end

  // Serial clock edges count only while the device is selected.
  assign sclk_rise = ~cs_n &  sclk & ~sclk_q;
  assign sclk_fall = ~cs_n & ~sclk &  sclk_q;
  assign cs_fall   =  cs_n_q & ~cs_n;

endmodule

// File: rtl/adc_ctrl_rx.sv
module adc_ctrl_rx
  import adc_ctl_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_stb,
  input  logic         din,
  input  logic         hunt_ok,
  input  logic         abort,
  output logic         busy,
  output logic         byte_done,
  output ctrl_fields_t fields
);

  localparam int CW = $clog2(CTRL_BITS);

  logic [CW-1:0]        cnt_q;
  logic [CTRL_BITS-2:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      byte_done <= 1'b0;
      fields    <= '0;
    end else begin
      byte_done <= 1'b0;
      if (abort) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else if (bit_stb) begin
        if (!busy) begin
          if (hunt_ok && din) begin
            busy  <= 1'b1;
            cnt_q <= CW'(1);
            sh_q  <= {{(CTRL_BITS-2){1'b0}}, 1'b1};
          end
        end else begin
          sh_q  <= {sh_q[CTRL_BITS-3:0], din};
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(CTRL_BITS-1)) begin
            busy      <= 1'b0;
            cnt_q     <= '0;
            byte_done <= 1'b1;
            fields    <= decode_ctrl({sh_q[CTRL_BITS-3:0], din});
          end
        end
      end
    end
  end

  AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) byte_done |=> !byte_done); // R3
  AST_RX_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (cnt_q != '0)); // R2

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire,
  output logic done
);

  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire = run_q && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= expire;
      if (start) begin
        run_q <= 1'b1;
        cnt_q <= CW'(CONV_CYCLES);
      end else if (expire) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (run_q) begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  AST_TIMER_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) run_q |-> (cnt_q != '0 && cnt_q <= CW'(CONV_CYCLES))); // R4

endmodule

// File: rtl/adc_result_tx.sv
module adc_result_tx #(
  parameter int RES_BITS  = 12,
  parameter int EARLY_BIT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [RES_BITS-1:0] data,
  input  logic                shift,
  input  logic                clear,
  output logic                dout,
  output logic                started,
  output logic                late
);

  localparam int SAT     = RES_BITS + 1;
  localparam int CW      = $clog2(SAT + 1);
  localparam int LATE_AT = RES_BITS - EARLY_BIT;

  logic [RES_BITS-1:0] sh_q;
  logic [CW-1:0]       cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      dout  <= 1'b0;
    end else if (clear) begin
      sh_q  <= '0;
      cnt_q <= '0;
      dout  <= 1'b0;
    end else if (load) begin
      sh_q  <= data;
      cnt_q <= '0;
      dout  <= 1'b0;
    end else if (shift) begin
      dout  <= sh_q[RES_BITS-1];
      sh_q  <= {sh_q[RES_BITS-2:0], 1'b0};
      if (cnt_q != CW'(SAT)) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign started = (cnt_q != '0);
  assign late    = (cnt_q >= CW'(LATE_AT));

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n) (shift && !clear && !load && cnt_q >= CW'(RES_BITS)) |=> !dout); // R5
  AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (late && !clear && !load) |=> late); // R7

endmodule

// File: rtl/adc_serial_ctl.sv
module adc_serial_ctl
  import adc_ctl_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int CONV_CYCLES = 2000,
  parameter int EARLY_BIT   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                din,
  input  logic [RES_BITS-1:0] conv_data,
  output logic                dout,
  output logic                dout_en,
  output logic                sstrb,
  output logic [2:0]          chan_sel,
  output logic                unipolar,
  output logic                single_ended,
  output logic [1:0]          clk_mode
);

  phase_t       phase_q;
  logic         pending_q;
  logic         sclk_rise, sclk_fall, cs_fall;
  logic         rx_busy, byte_done;
  ctrl_fields_t fields;
  logic         conv_expire, conv_done;
  logic         tx_started, tx_late;
  logic         hunt_ok, start_conv, readout_abort;

  adc_pin_sampler u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_fall   (cs_fall)
  );

  // A start bit is legal when nothing runs, or once the readout has shown the release bit.
  assign hunt_ok       = (phase_q == PH_IDLE) || (phase_q == PH_READ && tx_late);
  assign start_conv    = sclk_fall && (pending_q || byte_done);
  assign readout_abort = cs_fall && (phase_q == PH_READ) && tx_started;

  adc_ctrl_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (sclk_rise),
    .din       (din),
    .hunt_ok   (hunt_ok),
    .abort     (cs_fall),
    .busy      (rx_busy),
    .byte_done (byte_done),
    .fields    (fields)
  );

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_conv),
    .expire (conv_expire),
    .done   (conv_done)
  );

  adc_result_tx #(.RES_BITS(RES_BITS), .EARLY_BIT(EARLY_BIT)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (conv_expire),
    .data    (conv_data),
    .shift   (sclk_fall && phase_q == PH_READ),
    .clear   (start_conv || readout_abort),
    .dout    (dout),
    .started (tx_started),
    .late    (tx_late)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      pending_q <= 1'b0;
    end else begin
      if (cs_fall || start_conv) pending_q <= 1'b0;
      else if (byte_done)        pending_q <= 1'b1;

      if (readout_abort)     phase_q <= PH_IDLE;
      else if (start_conv)   phase_q <= PH_CONV;
      else if (conv_expire)  phase_q <= PH_READ;
    end
  end

  assign dout_en      = ~cs_n;
  assign sstrb        = conv_done && (fields.clk_mode != MODE_EXT);
  assign chan_sel     = fields.chan;
  assign unipolar     = fields.unipolar;
  assign single_ended = fields.single_ended;
  assign clk_mode     = fields.clk_mode;

  AST_CONV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_CONV && !conv_expire) |=> (phase_q == PH_CONV)); // R8
  AST_DESELECT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> $stable(dout)); // R8
  AST_NO_EARLY_FRAME: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_READ && !tx_late) |-> !rx_busy); // R6
  AST_FIELDS_STABLE_CONV: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_CONV) |=> $stable(fields)); // R3
  AST_STROBE_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n) $rose(sstrb) |-> ($past(phase_q) == PH_CONV)); // R4

endmodule

// File: tb/adc_serial_ctl_test.sv
module adc_serial_ctl_test;
  localparam int RB = 12;
  localparam int CC = 20;
  localparam int EB = 5;
  localparam int H  = 2;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [RB-1:0] conv_data = '0;
  logic dout, dout_en, sstrb, unipolar, single_ended;
  logic [2:0] chan_sel;
  logic [1:0] clk_mode;

  always #2.5 clk = ~clk;

  adc_serial_ctl #(.RES_BITS(RB), .CONV_CYCLES(CC), .EARLY_BIT(EB)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_data(conv_data), .dout(dout), .dout_en(dout_en), .sstrb(sstrb),
    .chan_sel(chan_sel), .unipolar(unipolar), .single_ended(single_ended),
    .clk_mode(clk_mode)
  );

  int n_tests = 0, n_fail = 0, strobes = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 converting, 2 reading out.
  int m_phase, m_timer, m_falls, m_rx_cnt, m_rx_byte;
  bit m_rx_act, m_pend, m_bdone, m_done, m_dout, p_sclk, p_cs;
  logic [7:0] m_fields;
  bit outq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_timer = 0; m_falls = 0; m_rx_cnt = 0; m_rx_byte = 0;
      m_rx_act = 0; m_pend = 0; m_bdone = 0; m_done = 0; m_dout = 0;
      p_sclk = 0; p_cs = 1; m_fields = 0; outq.delete();
    end else begin
      bit rise, fall, csf, hunt, start_now, abort_now, expire, bd_old;
      rise = !cs_n && sclk && !p_sclk;
      fall = !cs_n && !sclk && p_sclk;
      csf  = p_cs && !cs_n;
      hunt = (m_phase == 0) || (m_phase == 2 && m_falls >= RB - EB);
      bd_old = m_bdone;
      start_now = fall && (m_pend || bd_old);
      abort_now = csf && m_phase == 2 && m_falls > 0;
      expire = (m_phase == 1 && m_timer == 1);
      m_done = expire;
      m_bdone = 0;
      if (csf) m_rx_act = 0;
      else if (rise) begin
        if (!m_rx_act) begin
          if (hunt && din) begin m_rx_act = 1; m_rx_cnt = 1; m_rx_byte = 1; end
        end else begin
          m_rx_byte = (m_rx_byte << 1) | int'(din);
          m_rx_cnt++;
          if (m_rx_cnt == 8) begin m_rx_act = 0; m_bdone = 1; m_fields = m_rx_byte[7:0]; end
        end
      end
      if (csf || start_now) m_pend = 0;
      else if (bd_old) m_pend = 1;
      if (abort_now) begin
        m_phase = 0; outq.delete(); m_falls = 0; m_dout = 0;
      end else if (start_now) begin
        m_phase = 1; m_timer = CC; outq.delete(); m_falls = 0; m_dout = 0;
      end else if (expire) begin
        m_phase = 2; outq.delete(); m_falls = 0; m_dout = 0;
        for (int i = RB - 1; i >= 0; i--) outq.push_back(conv_data[i]);
      end else if (m_phase == 1) begin
        m_timer--;
      end else if (m_phase == 2 && fall) begin
        m_dout = (outq.size() > 0) ? outq.pop_front() : 1'b0;
        if (m_falls < RB + 1) m_falls++;
      end
      p_sclk = sclk;
      p_cs = cs_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 dout", dout, m_dout);
      chk("R4 sstrb", sstrb, m_done && m_fields[1:0] != 2'b11);
      chk("R3 fields", {chan_sel, unipolar, single_ended, clk_mode}, m_fields[6:0]);
      chk("R8 dout_en", dout_en, !cs_n);
      if (sstrb) strobes++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sbit(input logic d, output logic got);
    din = d; sclk = 1'b1; tick(H);
    sclk = 1'b0; tick(H);
    got = dout;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic g;
    for (int i = 7; i >= 0; i--) sbit(b[i], g);
    din = 1'b0;
  endtask

  task automatic read_word(input int nb, output logic [15:0] v);
    logic g;
    v = '0;
    for (int i = 0; i < nb; i++) begin sbit(1'b0, g); v = {v[14:0], g}; end
  endtask

  task automatic wait_strobe(output int n);
    n = 0;
    while (!sstrb && n < CC + 20) begin tick(1); n++; end
  endtask

  initial begin
    int n, s0;
    logic [15:0] v;
    logic g;
    logic [7:0] nb;
    tick(3);
    chk("R1 reset dout", dout, 0);
    chk("R1 reset sstrb", sstrb, 0);
    chk("R1 reset dout_en", dout_en, 0);
    chk("R1 reset fields", {chan_sel, unipolar, single_ended, clk_mode}, 0);
    rst_n = 1'b1; tick(2);

    // Deselected toggling with din high must not open a frame.
    repeat (2) sbit(1'b1, g);
    cs_n = 1'b0; tick(2);
    // R2: leading zeros ignored, first 1 is the start bit.
    conv_data = 12'h9C3;
    repeat (3) sbit(1'b0, g);
    send_byte(8'b1_101_1_0_10);
    wait_strobe(n);
    chk("R4 conversion length", n, CC - H + 1);
    chk("R2 start bit framing", {chan_sel, unipolar, single_ended, clk_mode}, 7'b101_1_0_10);
    chk("R3 chan_sel", chan_sel, 3'd5);
    read_word(RB, v);
    chk("R5 result msb first", v, 16'h09C3);
    read_word(3, v);
    chk("R5 zero fill", v, 0);

    // R6: start bits before B5 is shown are rejected.
    conv_data = 12'hA5C;
    send_byte(8'b1_010_0_1_10);
    wait_strobe(n);
    chk("R3 bipolar single-ended", {unipolar, single_ended}, 2'b01);
    v = '0;
    for (int k = 1; k <= RB; k++) begin sbit(k <= 7 ? 1'b1 : 1'b0, g); v = {v[14:0], g}; end
    chk("R6 readout intact", v, 16'h0A5C);
    s0 = strobes;
    tick(CC + 10);
    chk("R6 no frame opened", strobes - s0, 0);

    // R7: overlapped control byte after B5, 15 clocks per conversion.
    conv_data = 12'h3E7;
    send_byte(8'b1_111_1_1_10);
    wait_strobe(n);
    conv_data = 12'h5A1;
    nb = 8'b1_000_0_1_10;
    v = '0;
    for (int k = 1; k <= 15; k++) begin
      sbit(k <= 7 ? 1'b0 : nb[15 - k], g);
      if (k <= RB) v = {v[14:0], g};
    end
    din = 1'b0;
    chk("R7 readout during new frame", v, 16'h03E7);
    wait_strobe(n);
    chk("R7 restart timing", n, CC - H + 1);
    chk("R7 new channel", chan_sel, 3'd0);
    read_word(RB, v);
    chk("R7 second result", v, 16'h05A1);

    // R8: deselect during conversion.
    conv_data = 12'h0F0;
    send_byte(8'b1_011_1_1_10);
    cs_n = 1'b1; tick(1);
    repeat (4) sbit(1'b1, g);
    chk("R8 dout_en low", dout_en, 0);
    wait_strobe(n);
    chk("R8 conversion kept", sstrb, 1);
    cs_n = 1'b0; tick(2);
    read_word(RB, v);
    chk("R8 readout after reselect", v, 16'h00F0);
    chk("R8 fields untouched", chan_sel, 3'd3);

    // R9: abort mid-readout, immediate new frame.
    conv_data = 12'hFFF;
    send_byte(8'b1_100_0_0_10);
    wait_strobe(n);
    read_word(3, v);
    chk("R5 partial readout", v, 16'h0007);
    cs_n = 1'b1; tick(2);
    cs_n = 1'b0; tick(2);
    chk("R9 dout cleared", dout, 0);
    conv_data = 12'h123;
    send_byte(8'b1_110_1_0_10);
    wait_strobe(n);
    chk("R9 frame after abort", n, CC - H + 1);
    read_word(RB, v);
    chk("R9 result after abort", v, 16'h0123);

    // R10: external mode gives no strobe.
    conv_data = 12'h456;
    s0 = strobes;
    send_byte(8'b1_001_1_1_11);
    tick(CC + 10);
    chk("R10 no strobe", strobes - s0, 0);
    chk("R10 mode field", clk_mode, 2'b11);
    read_word(RB, v);
    chk("R10 readout", v, 16'h0456);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R1..: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule